// File: doc/BRIEF.md
# Sequential Restoring Unsigned Divider

This block divides an unsigned dividend by an unsigned divisor, both `N` bits wide, and returns an `N`-bit quotient and an `N`-bit remainder. It works one quotient bit per clock. Each divide keeps the dividend fixed in a double-width remainder register. The divisor starts in the upper half of a double-width register and moves one place right on every step. A trial subtraction decides each quotient bit. When the trial goes negative, the divisor is added back to restore the remainder.

A caller pulses `start_i` with both operands valid and then waits for the one-cycle `done_o` pulse. A zero divisor is not iterated. It finishes at once and raises `div_zero_o`. The results stay on the outputs until the next accepted start.

Top module: `rdiv_top`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `div_zero_o` are 0, and `quotient_o` and `remainder_o` are all zeros.
- R2: A start with a nonzero divisor, taken while idle, drives `busy_o` high from the next cycle for exactly N+1 cycles. `done_o` is high for exactly one cycle, the first cycle in which `busy_o` is low again.
- R3: At `done_o`, for a nonzero divisor, `quotient_o` equals the integer part of dividend/divisor, so that quotient*divisor + remainder equals the dividend.
- R4: At `done_o`, for a nonzero divisor, `remainder_o` equals dividend modulo divisor and is strictly less than the divisor.
- R5: A dividend of binary 1001010 divided by binary 1000 gives quotient binary 1001 and remainder binary 10.
- R6: With a zero divisor, `done_o` and `div_zero_o` are high in the cycle after the start cycle, `busy_o` stays low, `quotient_o` is all ones and `remainder_o` equals the dividend.
- R7: A `start_i` pulse while `busy_o` is high has no effect. The running divide returns its own result, and no extra `done_o` pulse follows.
- R8: While idle and with no start, `quotient_o`, `remainder_o` and `div_zero_o` hold their values. The next accepted start with a nonzero divisor clears `div_zero_o`.
- R9: When the dividend is smaller than the divisor, the quotient is 0 and the remainder equals the dividend. A dividend of all ones divided by 1 gives a quotient of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; operands are sampled with it |
| dividend_i | input | N | Unsigned dividend |
| divisor_i | input | N | Unsigned divisor |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | N | Quotient |
| remainder_o | output | N | Remainder |
| div_zero_o | output | 1 | Last divide had a zero divisor |

## Verification
The bench builds the block with N = 8. At that width the operand extremes (0, 1, 127, 128, 254 and 255) can be driven directly, and every quotient bit position, including the always-zero first trial, is used within ten-cycle divides. The exact N+1 latency is measured in cycles for each divide. The small width also keeps the checker's full-width product identity cheap, so it is evaluated at every completion.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  typedef enum logic {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
  import rdiv_pkg::*;
#(
  parameter int N = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic zero_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o,
  output logic dz_o
);
  localparam int CNT_W = $clog2(N + 1);

  div_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q, dz_q;
  logic             accept;

  assign accept = start_i && (state_q == DIV_IDLE);
  assign load_o = accept;
  assign step_o = (state_q == DIV_RUN);
  assign busy_o = (state_q == DIV_RUN);
  assign done_o = done_q;
  assign dz_o   = dz_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DIV_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      dz_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        dz_q <= zero_i;
        cnt_q <= '0;
        if (zero_i) done_q <= 1'b1;
        else state_q <= DIV_RUN;
      end else if (state_q == DIV_RUN) begin
        if (cnt_q == CNT_W'(N)) begin
          state_q <= DIV_IDLE;
          done_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rdiv_datapath.sv
module rdiv_datapath #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         zero_i,
  input  logic         step_i,
  input  logic [N-1:0] dividend_i,
  input  logic [N-1:0] divisor_i,
  output logic [N-1:0] quotient_o,
  output logic [N-1:0] remainder_o
);
  localparam int W = 2 * N;

  logic [W-1:0] rem_q, dvs_q;
  logic [N-1:0] quo_q;
  logic [W:0]   trial;
  logic         neg;
  logic [W-1:0] rem_next;

  // extra top bit catches the borrow when rem's upper half is zero
  assign trial    = {1'b0, rem_q} - {1'b0, dvs_q};
  assign neg      = trial[W];
  assign rem_next = neg ? (trial[W-1:0] + dvs_q) : trial[W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      dvs_q <= '0;
      quo_q <= '0;
    end else if (load_i) begin
      rem_q <= {{N{1'b0}}, dividend_i};
      dvs_q <= {divisor_i, {N{1'b0}}};
      quo_q <= zero_i ? '1 : '0;
    end else if (step_i) begin
      rem_q <= rem_next;
      quo_q <= {quo_q[N-2:0], ~neg};
      dvs_q <= dvs_q >> 1;
    end
  end

  assign quotient_o  = quo_q;
  assign remainder_o = rem_q[N-1:0];
endmodule

// File: rtl/rdiv_top.sv
module rdiv_top #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [N-1:0] dividend_i,
  input  logic [N-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [N-1:0] quotient_o,
  output logic [N-1:0] remainder_o,
  output logic         div_zero_o
);
  logic zero, load, step;

  assign zero = (divisor_i == '0);

  rdiv_ctrl #(.N(N)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .zero_i (zero),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o),
    .dz_o   (div_zero_o)
  );

  rdiv_datapath #(.N(N)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .zero_i     (zero),
    .step_i     (step),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .quotient_o (quotient_o),
    .remainder_o(remainder_o)
  );
endmodule

// File: rtl/rdiv_chk.sv
module rdiv_chk #(
  parameter int N = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [N-1:0] dividend_i,
  input logic [N-1:0] divisor_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [N-1:0] quotient_o,
  input logic [N-1:0] remainder_o,
  input logic         div_zero_o
);
  localparam int W = 2 * N;
  logic [N-1:0] a_q, b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (start_i && !busy_o) begin
      a_q <= dividend_i;
      b_q <= divisor_i;
    end
  end

  assert_done_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_busy_end_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_identity_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !div_zero_o) |->
      (W'(quotient_o) * W'(b_q) + W'(remainder_o) == W'(a_q)));

  assert_rem_lt_div_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !div_zero_o) |-> (remainder_o < b_q));

  assert_zero_div_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && div_zero_o) |-> ((quotient_o == '1) && (remainder_o == a_q) && !busy_o));

  assert_hold_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !busy_o) |=>
      ($stable(quotient_o) && $stable(remainder_o) && $stable(div_zero_o)));
endmodule

bind rdiv_top rdiv_chk #(.N(N)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .dividend_i (dividend_i),
  .divisor_i  (divisor_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .quotient_o (quotient_o),
  .remainder_o(remainder_o),
  .div_zero_o (div_zero_o)
);

// File: tb/sim_rdiv_top.sv
`timescale 1ns/1ps
module sim_rdiv_top;
  localparam int N  = 8;
  localparam int NV = 10;
  localparam logic [N-1:0] TV_A [NV] = '{8'd74, 8'd255, 8'd255, 8'd3,  8'd0,
                                          8'd200, 8'd128, 8'd1, 8'd254, 8'd100};
  localparam logic [N-1:0] TV_B [NV] = '{8'd8,  8'd1,   8'd255, 8'd200, 8'd9,
                                          8'd7,   8'd3,   8'd1, 8'd127, 8'd10};

  logic clk, rst_n, start;
  logic [N-1:0] a, b;
  logic busy, done, dz;
  logic [N-1:0] q, r;
  int checks = 0, errors = 0;

  rdiv_top #(.N(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .dividend_i(a), .divisor_i(b),
    .busy_o(busy), .done_o(done),
    .quotient_o(q), .remainder_o(r), .div_zero_o(dz)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Issues one divide; returns cycles from start edge to done (negedge count)
  task automatic run_div(input logic [N-1:0] da, input logic [N-1:0] db,
                         input int mid_start, output int lat);
    int c;
    @(negedge clk);
    a = da; b = db; start = 1'b1;
    c = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      c++;
      if (c == 1 && db != 0) chk("R2 busy after start", int'(busy), 1);
      if (mid_start != 0 && c == mid_start) begin
        a = 8'd5; b = 8'd1; start = 1'b1;
      end
    end while (!done && c < 100);
    start = 1'b0;
    lat = c;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    logic [N-1:0] hq, hr;
    start = 1'b0; a = '0; b = '0; rst_n = 1'b0;
    #12;
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 dz", int'(dz), 0);
    chk("R1 quotient", int'(q), 0);
    chk("R1 remainder", int'(r), 0);
    @(negedge clk); rst_n = 1'b1;

    // vector table: R3 R4 R5 R9 and R2 latency
    for (int i = 0; i < NV; i++) begin
      run_div(TV_A[i], TV_B[i], 0, lat);
      chk("R2 latency", lat, N + 2);
      chk("R3 quotient", int'(q), int'(TV_A[i] / TV_B[i]));
      chk("R4 remainder", int'(r), int'(TV_A[i] % TV_B[i]));
      chk("R4 rem<div", int'(r < TV_B[i]), 1);
      chk("R2 dz low", int'(dz), 0);
      @(negedge clk);
      chk("R2 done single", int'(done), 0);
      chk("R2 busy low", int'(busy), 0);
    end

    // R5 worked example 1001010 / 1000
    run_div(8'b1001010, 8'b1000, 0, lat);
    chk("R5 quotient", int'(q), 9);
    chk("R5 remainder", int'(r), 2);

    // R9 dividend below divisor, all ones by one
    run_div(8'd17, 8'd18, 0, lat);
    chk("R9 quotient zero", int'(q), 0);
    chk("R9 remainder", int'(r), 17);
    run_div(8'd255, 8'd1, 0, lat);
    chk("R9 quotient ones", int'(q), 255);

    // R6 zero divisor
    run_div(8'd77, 8'd0, 0, lat);
    chk("R6 latency", lat, 1);
    chk("R6 dz", int'(dz), 1);
    chk("R6 busy", int'(busy), 0);
    chk("R6 quotient", int'(q), 255);
    chk("R6 remainder", int'(r), 77);

    // R8 hold while idle, inputs changing
    hq = q; hr = r;
    @(negedge clk); a = 8'd9; b = 8'd3;
    repeat (5) @(negedge clk);
    chk("R8 quotient hold", int'(q), int'(hq));
    chk("R8 remainder hold", int'(r), int'(hr));
    chk("R8 dz hold", int'(dz), 1);
    run_div(8'd9, 8'd3, 0, lat);
    chk("R8 dz cleared", int'(dz), 0);
    chk("R8 quotient", int'(q), 3);

    // R7 start while busy ignored
    run_div(8'd200, 8'd7, 3, lat);
    chk("R7 latency", lat, N + 2);
    chk("R7 quotient", int'(q), 28);
    chk("R7 remainder", int'(r), 4);
    repeat (N + 4) begin
      @(negedge clk);
      chk("R7 no extra done", int'(done), 0);
    end
    chk("R7 idle", int'(busy), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule